// File: doc/BRIEF.md
# T1 Receive Data Link Extractor

This block sits on the receive side of a T1 line interface, ahead of any elastic buffering. It watches the raw line bit stream together with a bit strobe and a superframe marker. It tracks where each bit falls in the 193-bit frame and in the 24-frame superframe. From that position it picks out the data link bits. These are either the framing-bit positions that carry the link (the facility link in extended-superframe mode, the signalling framing bits in D4 mode) or the bits of one chosen payload timeslot. Each picked bit goes to one of two serial ports: an external data link port or an internal HDLC receive port.

The block also drives a receive data link clock pin, which has three modes. It can repeat a continuous line-rate clock taken from an external clock input. It can give a clock that pulses only while an external-port bit is current. It can give an active-low enable that is low only while such a bit is current. The timeslot path runs at 64 kb/s, taking all eight bits, or at 56 kb/s, taking seven.

Top module: `dl_rx_extract`

## Requirements
- R1: While rst_ni is low, ext_vld_o and hdlc_vld_o are 0 and dl_clk_o is 1.
- R2: A bit strobed with sf_sync_i high is the framing bit (position 0) of frame 0. Positions 1..192 are timeslots 0..23, eight bits each, first-received bit first. After position 192 the next bit is position 0 of the next frame. Frames count 0..23 and then wrap to 0 without a new marker.
- R3: In ESF mode (esf_i=1) without HDLC on the facility link, the framing bit of every even-numbered frame (0,2,..,22) is sent on the external port.
- R4: In D4 mode (esf_i=0), the framing bit of every odd-numbered frame (1,3,..,23) is sent on the external port. No other bit goes there.
- R5: With hdlc_en_i=1, pay_sel_i=0 and esf_i=1, the facility link bits go to the HDLC port and ext_vld_o never asserts.
- R6: With hdlc_en_i=1, pay_sel_i=1 and rate64_i=1, all eight bits of timeslot chan_i go to the HDLC port in order. The framing bits still follow R3/R4 on the external port. Payload extraction needs both hdlc_en_i and pay_sel_i.
- R7: With rate64_i=0, only the first seven bits of the chosen timeslot go to the HDLC port. The eighth bit is dropped.
- R8: A chan_i value of 24 or above selects no timeslot: hdlc_vld_o stays 0 while pay_sel_i=1.
- R9: Each picked bit is output as the data bit plus a one-cycle valid. The valid comes on the clock edge after the strobe that carried the bit. ext_vld_o and hdlc_vld_o are never high together.
- R10: With xck_i=1, dl_clk_o repeats ext_ck_i one cycle later, whatever bits are selected.
- R11: With xck_i=0 and dl_gap_i=1, dl_clk_o repeats ext_ck_i one cycle later, but only during the bit period of an external-port bit. Otherwise it is 0.
- R12: With xck_i=0 and dl_gap_i=0, dl_clk_o is 0 during the bit period of an external-port bit and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_bit_i | input | 1 | Receive line data, before buffering |
| bit_stb_i | input | 1 | One-cycle strobe marking each line bit |
| sf_sync_i | input | 1 | Superframe marker, valid with bit_stb_i |
| ext_ck_i | input | 1 | External line-rate clock level |
| esf_i | input | 1 | 1 = ESF framing, 0 = D4 framing |
| hdlc_en_i | input | 1 | Attach internal HDLC port |
| pay_sel_i | input | 1 | 1 = HDLC on a payload timeslot, 0 = on the facility link |
| rate64_i | input | 1 | 1 = 8 bits per slot, 0 = 7 bits per slot |
| chan_i | input | 5 | Timeslot number for the HDLC port |
| dl_gap_i | input | 1 | 1 = gapped clock, 0 = active-low enable |
| xck_i | input | 1 | 1 = continuous clock from ext_ck_i |
| ext_dat_o | output | 1 | External data link bit |
| ext_vld_o | output | 1 | External bit valid |
| hdlc_dat_o | output | 1 | HDLC receive bit |
| hdlc_vld_o | output | 1 | HDLC bit valid |
| dl_clk_o | output | 1 | Receive data link clock / enable pin |

## Verification
A bit strobed at edge N shows up as a data/valid pair after edge N. The bench therefore reads the valids at the falling edge that follows the strobe edge. A scoreboard queue holds the bits expected at each port, pushed by the driver from its own position count, and a monitor pops one entry for each valid it sees. The clock pin is one register behind the window, so it is sampled at the falling edge after the second rising edge of each bit (external clock high), and again at the fourth (external clock low). The window in use then belongs to the bit just strobed.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_EXT  = 2'd1,
    DST_HDLC = 2'd2
  } dl_dst_e;

  typedef struct packed {
    logic       esf;
    logic       hdlc_en;
    logic       pay_sel;
    logic       rate64;
    logic [4:0] chan;
  } dl_sel_cfg_t;
endpackage

// File: rtl/dlx_pos_track.sv
module dlx_pos_track #(
  parameter int unsigned FRM_BITS    = 193,
  parameter int unsigned FRMS_PER_SF = 24,
  localparam int unsigned BIT_W = $clog2(FRM_BITS),
  localparam int unsigned FRM_W = $clog2(FRMS_PER_SF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             sf_sync_i,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic [FRM_W-1:0] frm_idx_o
);
  logic [BIT_W-1:0] nxt_bit_q;
  logic [FRM_W-1:0] nxt_frm_q;

  // position of the bit on the current strobe
  always_comb begin
    if (sf_sync_i) begin
      bit_idx_o = '0;
      frm_idx_o = '0;
    end else begin
      bit_idx_o = nxt_bit_q;
      frm_idx_o = nxt_frm_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_bit_q <= '0;
      nxt_frm_q <= '0;
    end else if (bit_stb_i) begin
      if (bit_idx_o == BIT_W'(FRM_BITS - 1)) begin
        nxt_bit_q <= '0;
        nxt_frm_q <= (frm_idx_o == FRM_W'(FRMS_PER_SF - 1)) ? '0 : frm_idx_o + FRM_W'(1);
      end else begin
        nxt_bit_q <= bit_idx_o + BIT_W'(1);
        nxt_frm_q <= frm_idx_o;
      end
    end
  end
endmodule

// File: rtl/dlx_select.sv
module dlx_select import dlx_pkg::*; #(
  parameter int unsigned BIT_W       = 8,
  parameter int unsigned FRM_W       = 5,
  parameter int unsigned TS_PER_FRM  = 24,
  parameter int unsigned BITS_PER_TS = 8
) (
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic [FRM_W-1:0] frm_idx_i,
  input  dl_sel_cfg_t      cfg_i,
  output dl_dst_e          dst_o
);
  logic             is_fbit;
  logic [BIT_W-1:0] slot_off;
  logic [BIT_W-1:0] ts_num;
  logic [BIT_W-1:0] ts_bit;
  logic             link_pos;
  logic             fdl_to_hdlc;
  logic             chan_ok;
  logic             ts_hit;

  assign is_fbit  = (bit_idx_i == '0);
  assign slot_off = bit_idx_i - BIT_W'(1);
  assign ts_num   = slot_off / BIT_W'(BITS_PER_TS);
  assign ts_bit   = slot_off % BIT_W'(BITS_PER_TS);

  // ESF link on even frame index, D4 Fs on odd index
  assign link_pos    = is_fbit & (cfg_i.esf ? ~frm_idx_i[0] : frm_idx_i[0]);
  assign fdl_to_hdlc = cfg_i.hdlc_en & ~cfg_i.pay_sel & cfg_i.esf;
  assign chan_ok     = (cfg_i.chan < 5'(TS_PER_FRM));
  assign ts_hit      = cfg_i.hdlc_en & cfg_i.pay_sel & chan_ok & ~is_fbit
                     & (ts_num == BIT_W'(cfg_i.chan))
                     & (cfg_i.rate64 | (ts_bit != BIT_W'(BITS_PER_TS - 1)));

  always_comb begin
    if (ts_hit)                     dst_o = DST_HDLC;
    else if (link_pos && fdl_to_hdlc) dst_o = DST_HDLC;
    else if (link_pos)              dst_o = DST_EXT;
    else                            dst_o = DST_NONE;
  end
endmodule

// File: rtl/dlx_clk_gen.sv
module dlx_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic win_set_i,
  input  logic ext_ck_i,
  input  logic xck_i,
  input  logic gap_i,
  output logic dl_clk_o
);
  logic win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= 1'b0;
      dl_clk_o <= 1'b1;
    end else begin
      if (bit_stb_i) win_q <= win_set_i;
      if (xck_i)      dl_clk_o <= ext_ck_i;
      else if (gap_i) dl_clk_o <= ext_ck_i & win_q;
      else            dl_clk_o <= ~win_q;
    end
  end
endmodule

// File: rtl/dl_rx_extract.sv
module dl_rx_extract import dlx_pkg::*; #(
  parameter int unsigned FRM_BITS    = 193,
  parameter int unsigned FRMS_PER_SF = 24,
  parameter int unsigned TS_PER_FRM  = 24,
  parameter int unsigned BITS_PER_TS = 8,
  localparam int unsigned BIT_W = $clog2(FRM_BITS),
  localparam int unsigned FRM_W = $clog2(FRMS_PER_SF)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_bit_i,
  input  logic       bit_stb_i,
  input  logic       sf_sync_i,
  input  logic       ext_ck_i,
  input  logic       esf_i,
  input  logic       hdlc_en_i,
  input  logic       pay_sel_i,
  input  logic       rate64_i,
  input  logic [4:0] chan_i,
  input  logic       dl_gap_i,
  input  logic       xck_i,
  output logic       ext_dat_o,
  output logic       ext_vld_o,
  output logic       hdlc_dat_o,
  output logic       hdlc_vld_o,
  output logic       dl_clk_o
);
  logic [BIT_W-1:0] bit_idx;
  logic [FRM_W-1:0] frm_idx;
  dl_sel_cfg_t      cfg;
  dl_dst_e          dst;

  assign cfg = '{esf: esf_i, hdlc_en: hdlc_en_i, pay_sel: pay_sel_i,
                 rate64: rate64_i, chan: chan_i};

  dlx_pos_track #(.FRM_BITS(FRM_BITS), .FRMS_PER_SF(FRMS_PER_SF)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb_i),
    .sf_sync_i (sf_sync_i),
    .bit_idx_o (bit_idx),
    .frm_idx_o (frm_idx)
  );

  dlx_select #(.BIT_W(BIT_W), .FRM_W(FRM_W), .TS_PER_FRM(TS_PER_FRM),
               .BITS_PER_TS(BITS_PER_TS)) u_sel (
    .bit_idx_i (bit_idx),
    .frm_idx_i (frm_idx),
    .cfg_i     (cfg),
    .dst_o     (dst)
  );

  dlx_clk_gen u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_stb_i (bit_stb_i),
    .win_set_i (dst == DST_EXT),
    .ext_ck_i  (ext_ck_i),
    .xck_i     (xck_i),
    .gap_i     (dl_gap_i),
    .dl_clk_o  (dl_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_dat_o  <= 1'b0;
      ext_vld_o  <= 1'b0;
      hdlc_dat_o <= 1'b0;
      hdlc_vld_o <= 1'b0;
    end else begin
      ext_vld_o  <= bit_stb_i && (dst == DST_EXT);
      hdlc_vld_o <= bit_stb_i && (dst == DST_HDLC);
      if (bit_stb_i && dst == DST_EXT)  ext_dat_o  <= rx_bit_i;
      if (bit_stb_i && dst == DST_HDLC) hdlc_dat_o <= rx_bit_i;
    end
  end
endmodule

// File: rtl/dl_rx_extract_chk.sv
module dl_rx_extract_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_stb_i,
  input logic       ext_ck_i,
  input logic       esf_i,
  input logic       hdlc_en_i,
  input logic       pay_sel_i,
  input logic [4:0] chan_i,
  input logic       dl_gap_i,
  input logic       xck_i,
  input logic       ext_vld_o,
  input logic       hdlc_vld_o,
  input logic       dl_clk_o
);
  assert_vld_after_stb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_vld_o || hdlc_vld_o) |-> $past(bit_stb_i));

  assert_vld_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_vld_o, hdlc_vld_o}));

  assert_fdl_no_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hdlc_en_i && !pay_sel_i && esf_i) |-> !ext_vld_o);

  assert_bad_chan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pay_sel_i && chan_i >= 5'd24) |-> !hdlc_vld_o);

  assert_xck_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(xck_i)) |-> (dl_clk_o == $past(ext_ck_i)));

  assert_gap_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xck_i && dl_gap_i && !ext_ck_i) |=> !dl_clk_o);

  assert_en_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_vld_o && !xck_i && !dl_gap_i) |=> !dl_clk_o);
endmodule

bind dl_rx_extract dl_rx_extract_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_stb_i  (bit_stb_i),
  .ext_ck_i   (ext_ck_i),
  .esf_i      (esf_i),
  .hdlc_en_i  (hdlc_en_i),
  .pay_sel_i  (pay_sel_i),
  .chan_i     (chan_i),
  .dl_gap_i   (dl_gap_i),
  .xck_i      (xck_i),
  .ext_vld_o  (ext_vld_o),
  .hdlc_vld_o (hdlc_vld_o),
  .dl_clk_o   (dl_clk_o)
);

// File: tb/dl_rx_extract_tb.sv
module dl_rx_extract_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_bit_i = 1'b0, bit_stb_i = 1'b0, sf_sync_i = 1'b0, ext_ck_i = 1'b0;
  logic esf_i = 1'b1, hdlc_en_i = 1'b0, pay_sel_i = 1'b0, rate64_i = 1'b1;
  logic [4:0] chan_i = 5'd0;
  logic dl_gap_i = 1'b1, xck_i = 1'b0;
  logic ext_dat_o, ext_vld_o, hdlc_dat_o, hdlc_vld_o, dl_clk_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int q_dst[$];
  bit q_dat[$];
  string cur_req = "R3";
  int f_cnt = 0;
  int b_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk_i = ~clk_i;

  dl_rx_extract u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_bit_i(rx_bit_i), .bit_stb_i(bit_stb_i),
    .sf_sync_i(sf_sync_i), .ext_ck_i(ext_ck_i), .esf_i(esf_i), .hdlc_en_i(hdlc_en_i),
    .pay_sel_i(pay_sel_i), .rate64_i(rate64_i), .chan_i(chan_i), .dl_gap_i(dl_gap_i),
    .xck_i(xck_i), .ext_dat_o(ext_dat_o), .ext_vld_o(ext_vld_o), .hdlc_dat_o(hdlc_dat_o),
    .hdlc_vld_o(hdlc_vld_o), .dl_clk_o(dl_clk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 none, 1 external port, 2 HDLC port
  function automatic int exp_dst(input int f, input int b);
    bit link;
    int ts, k;
    if (b == 0) begin
      link = esf_i ? (f % 2 == 0) : (f % 2 == 1);
      if (!link) return 0;
      if (hdlc_en_i && !pay_sel_i && esf_i) return 2;
      return 1;
    end
    if (!(hdlc_en_i && pay_sel_i)) return 0;
    if (chan_i >= 5'd24) return 0;
    ts = (b - 1) / 8;
    k  = (b - 1) % 8;
    if (ts != int'(chan_i)) return 0;
    if (!rate64_i && k == 7) return 0;
    return 2;
  endfunction

  function automatic string clk_req();
    if (xck_i) return "R10";
    if (dl_gap_i) return "R11";
    return "R12";
  endfunction

  task automatic send_bit(input bit sync);
    int dst;
    bit d;
    bit e_a, e_b;
    d = lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dst = exp_dst(f_cnt, b_cnt);
    if (dst != 0) begin
      q_dst.push_back(dst);
      q_dat.push_back(d);
    end
    rx_bit_i = d; bit_stb_i = 1'b1; sf_sync_i = sync; ext_ck_i = 1'b1;
    @(negedge clk_i);
    bit_stb_i = 1'b0; sf_sync_i = 1'b0;
    @(negedge clk_i);
    e_a = xck_i ? 1'b1 : (dl_gap_i ? (dst == 1) : (dst != 1));
    check(dl_clk_o == e_a, clk_req(), dl_clk_o, e_a);
    ext_ck_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    e_b = xck_i ? 1'b0 : (dl_gap_i ? 1'b0 : (dst != 1));
    check(dl_clk_o == e_b, clk_req(), dl_clk_o, e_b);
    if (b_cnt == 192) begin
      b_cnt = 0;
      f_cnt = (f_cnt + 1) % 24; // R2 frame wrap
    end else b_cnt++;
  endtask

  task automatic run_frames(input int n, input bit first_sync);
    for (int i = 0; i < n * 193; i++) send_bit(first_sync && i == 0);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && (ext_vld_o || hdlc_vld_o)) begin
      if (ext_vld_o && hdlc_vld_o) check(1'b0, "R9 both valids", 3, 1);
      if (q_dst.size() == 0) begin
        check(1'b0, "R9 unexpected valid", ext_vld_o ? 1 : 2, 0);
      end else begin
        int e_dst;
        bit e_dat;
        int g_dst;
        bit g_dat;
        e_dst = q_dst.pop_front();
        e_dat = q_dat.pop_front();
        g_dst = ext_vld_o ? 1 : 2;
        g_dat = ext_vld_o ? ext_dat_o : hdlc_dat_o;
        check(g_dst == e_dst, {cur_req, " port"}, g_dst, e_dst);
        check(g_dat == e_dat, {cur_req, " data"}, g_dat, e_dat);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(ext_vld_o == 1'b0, "R1 ext_vld", ext_vld_o, 0);
    check(hdlc_vld_o == 1'b0, "R1 hdlc_vld", hdlc_vld_o, 0);
    check(dl_clk_o == 1'b1, "R1 dl_clk", dl_clk_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 ESF link to external, gapped clock; R2 position from marker
    cur_req = "R3 R2"; esf_i = 1; hdlc_en_i = 0; pay_sel_i = 0; dl_gap_i = 1; xck_i = 0;
    run_frames(4, 1'b1);
    // R4 D4 framing bits, enable mode
    cur_req = "R4"; esf_i = 0; dl_gap_i = 0;
    run_frames(4, 1'b0);
    // R5 link bits to HDLC, continuous clock
    cur_req = "R5"; esf_i = 1; hdlc_en_i = 1; xck_i = 1;
    run_frames(4, 1'b0);
    // R6 timeslot 5 at 64 kb/s
    cur_req = "R6"; pay_sel_i = 1; chan_i = 5'd5; rate64_i = 1; xck_i = 0; dl_gap_i = 0;
    run_frames(4, 1'b0);
    // R7 last timeslot at 56 kb/s
    cur_req = "R7"; chan_i = 5'd23; rate64_i = 0; dl_gap_i = 1;
    run_frames(4, 1'b0);
    // R7 first timeslot at 56 kb/s, D4
    cur_req = "R7 D4"; chan_i = 5'd0; esf_i = 0; dl_gap_i = 0;
    run_frames(4, 1'b0);
    // R8 out-of-range channels, after the R2 frame wrap
    cur_req = "R8 R2"; esf_i = 1; chan_i = 5'd24; rate64_i = 1; xck_i = 1;
    run_frames(2, 1'b0);
    chan_i = 5'd31;
    run_frames(2, 1'b0);

    repeat (4) @(negedge clk_i);
    check(q_dst.size() == 0, "R9 missing valids", q_dst.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule